// File: doc/BRIEF.md
# Byte-Programmed Single-Channel PWM with Auto-Off Timer

This block generates one active-high pulse-width-modulated output from a 16-bit period and a 16-bit duty value. Both are counted in ticks of an external 8 MHz tick-enable pulse, so one unit is 125 ns. A host programs it by writing bytes through an 8-bit address and data port. Each 16-bit setting is split into a high byte and a low byte. Writing the high byte only stages it. Writing the low byte commits the full word at once, so a half-written value never reaches the output.

An enable register starts and stops the output. A 16-bit auto-off timer can shut the output down by itself. The timer counts completed PWM periods and clears the enable bit when it runs out. Loading the timer value 0xFFFF turns the timer off.

The write port is a valid/ready stream. `wr_ready` is always high, so the block never applies back-pressure. Every cycle in which `wr_valid` is high is one accepted write. The registers are write-only.

Top module: `pwm_bytewise`

## Requirements
- R1: After a synchronous active-high reset the output is low, enable is 0, period and duty are 0, and auto-off is disabled (0xFFFF). The staged high bytes are 0.
- R2: `wr_ready` is always 1. A write takes effect only in a cycle with `wr_valid` high. An address and data presented with `wr_valid` low change nothing.
- R3: A high-byte write (period 0xA5, duty 0xA7, auto-off 0xA1) only stages the byte and leaves the output unchanged. The low-byte write (period 0xA4, duty 0xA6, auto-off 0xA2) commits the word {staged high byte, written low byte} in that same clock edge.
- R4: While enabled with period P > 0 and duty D < P, the output is high for the first D ticks of each cycle and low for the remaining P − D ticks. It repeats every P ticks. The first cycle begins in the cycle after the enabling write.
- R5: When D ≥ P, with P > 0 and enabled, the output stays high. When D = 0 it stays low.
- R6: A period of 0 holds the output low, even while enabled.
- R7: Writing to address 0xA3 loads bit 0 of the data into enable. The other bits are ignored. Enable 0 drives the output low from the next cycle and resets the count, so a later enable starts a fresh cycle.
- R8: A committed period restarts the cycle at tick 0 in the cycle after the low-byte write.
- R9: A committed duty value acts on the compare from the next cycle, without restarting the cycle.
- R10: With an auto-off value N other than 0xFFFF, committing N loads the countdown. Each completed period while enabled counts it down. The period completion that finds the countdown at 1 or 0 clears enable, so an N written before enabling gives exactly N periods (N = 0 acts as 1).
- R11: With auto-off 0xFFFF, the output is never switched off by the timer.
- R12: The cycle count advances only on clocks where `tick` is high. With `tick` low the output holds its level.
- R13: Writes to addresses outside 0xA1 to 0xA7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 8 MHz time-base enable, one clock wide per tick |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write accepted (always 1) |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Register data byte |
| pwm_out | output | 1 | Active-high PWM output |

## Verification
The hardest state to reach from the ports is an auto-off reload that lands in the middle of a countdown. The expiry clock edge then depends on the new value, on how far the current period has run, and on the point of the write within that period. The bench reaches this state by arming a short countdown and letting two periods complete. It then commits a fresh low byte at a known sample index and predicts the exact sample at which the output must drop. The period-restart and duty-immediacy checks use the same exact sample indexing: each one writes at a count where the old setting and the new one give different output levels.

// File: rtl/pwm_bytewise_pkg.sv
package pwm_bytewise_pkg;

  // Slot indices of the byte-pair programmed words.
  localparam int SLOT_PERIOD = 0;
  localparam int SLOT_DUTY   = 1;
  localparam int SLOT_AOFF   = 2;
  localparam int NUM_SLOTS   = 3;

  // Default register addresses, kept because host firmware decodes them.
  localparam logic [7:0] DEF_AOFF_HI = 8'hA1;
  localparam logic [7:0] DEF_AOFF_LO = 8'hA2;
  localparam logic [7:0] DEF_ENABLE  = 8'hA3;
  localparam logic [7:0] DEF_PER_LO  = 8'hA4;
  localparam logic [7:0] DEF_PER_HI  = 8'hA5;
  localparam logic [7:0] DEF_DUTY_LO = 8'hA6;
  localparam logic [7:0] DEF_DUTY_HI = 8'hA7;

endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_bytewise_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [NUM_SLOTS-1:0][ADDR_W-1:0] ADR_HI = {DEF_AOFF_HI, DEF_DUTY_HI, DEF_PER_HI},
  parameter logic [NUM_SLOTS-1:0][ADDR_W-1:0] ADR_LO = {DEF_AOFF_LO, DEF_DUTY_LO, DEF_PER_LO},
  parameter logic [ADDR_W-1:0] ADR_EN = DEF_ENABLE,
  localparam int WORD_W = 2 * DATA_W
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               wr_fire,
  input  logic [ADDR_W-1:0]                  wr_addr,
  input  logic [DATA_W-1:0]                  wr_data,
  input  logic                               expire,
  output logic                               en_q,
  output logic [NUM_SLOTS-1:0][WORD_W-1:0]   word_q,
  output logic [NUM_SLOTS-1:0][WORD_W-1:0]   word_next,
  output logic [NUM_SLOTS-1:0]               commit
);

  logic en_hit;
  assign en_hit = wr_fire && (wr_addr == ADR_EN);

  // Enable: a host write wins over a same-cycle timer expiry.
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
    end else if (en_hit) begin
      en_q <= wr_data[0];
    end else if (expire) begin
      en_q <= 1'b0;
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam logic [WORD_W-1:0] RST_VAL =
      (s == SLOT_AOFF) ? {WORD_W{1'b1}} : {WORD_W{1'b0}};

    logic              hi_hit;
    logic              lo_hit;
    logic [DATA_W-1:0] stage_q;
    logic [WORD_W-1:0] val_q;

    assign hi_hit = wr_fire && (wr_addr == ADR_HI[s]);
    assign lo_hit = wr_fire && (wr_addr == ADR_LO[s]);

    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q <= '0;
        val_q   <= RST_VAL;
      end else begin
        if (hi_hit) stage_q <= wr_data;
        if (lo_hit) val_q   <= {stage_q, wr_data};
      end
    end

    assign word_q[s]    = val_q;
    assign word_next[s] = {stage_q, wr_data};
    assign commit[s]    = lo_hit;
  end

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             en,
  input  logic             restart,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] duty,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap,
  output logic             pwm_out
);

  logic             run;
  logic             at_end;
  logic [CNT_W-1:0] last_tick;

  assign run       = en && (period != '0);
  assign last_tick = period - 1'b1;
  assign at_end    = (cnt_q >= last_tick);
  assign wrap      = run && tick && at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!run || restart) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= at_end ? '0 : cnt_q + 1'b1;
    end
  end

  // High for the first `duty` ticks; duty >= period gives a steady high.
  assign pwm_out = run && (cnt_q < duty);

endmodule

// File: rtl/pwm_autooff.sv
module pwm_autooff #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] limit,
  input  logic             wrap,
  output logic             expire
);

  logic             active;
  logic [CNT_W-1:0] remain_q;

  assign active = (limit != {CNT_W{1'b1}});
  assign expire = wrap && active && !load && (remain_q <= 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= {CNT_W{1'b1}};
    end else if (load) begin
      remain_q <= load_val;
    end else if (wrap && active) begin
      remain_q <= (remain_q > 1) ? remain_q - 1'b1 : '0;
    end
  end

endmodule

// File: rtl/pwm_bytewise.sv
module pwm_bytewise
  import pwm_bytewise_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADR_AOFF_HI = DEF_AOFF_HI,
  parameter logic [ADDR_W-1:0] ADR_AOFF_LO = DEF_AOFF_LO,
  parameter logic [ADDR_W-1:0] ADR_EN      = DEF_ENABLE,
  parameter logic [ADDR_W-1:0] ADR_PER_LO  = DEF_PER_LO,
  parameter logic [ADDR_W-1:0] ADR_PER_HI  = DEF_PER_HI,
  parameter logic [ADDR_W-1:0] ADR_DUTY_LO = DEF_DUTY_LO,
  parameter logic [ADDR_W-1:0] ADR_DUTY_HI = DEF_DUTY_HI,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pwm_out
);

  logic                              wr_fire;
  logic                              en_q;
  logic                              expire;
  logic                              wrap;
  logic [NUM_SLOTS-1:0][CNT_W-1:0]   word_q;
  logic [NUM_SLOTS-1:0][CNT_W-1:0]   word_next;
  logic [NUM_SLOTS-1:0]              commit;
  logic [CNT_W-1:0]                  period_q;
  logic [CNT_W-1:0]                  duty_q;
  logic [CNT_W-1:0]                  aoff_q;
  logic [CNT_W-1:0]                  cnt_q;
  logic                              period_commit;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid && wr_ready;

  pwm_regfile #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .ADR_HI ({ADR_AOFF_HI, ADR_DUTY_HI, ADR_PER_HI}),
    .ADR_LO ({ADR_AOFF_LO, ADR_DUTY_LO, ADR_PER_LO}),
    .ADR_EN (ADR_EN)
  ) i_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_fire   (wr_fire),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .expire    (expire),
    .en_q      (en_q),
    .word_q    (word_q),
    .word_next (word_next),
    .commit    (commit)
  );

  assign period_q      = word_q[SLOT_PERIOD];
  assign duty_q        = word_q[SLOT_DUTY];
  assign aoff_q        = word_q[SLOT_AOFF];
  assign period_commit = commit[SLOT_PERIOD];

  pwm_counter #(
    .CNT_W (CNT_W)
  ) i_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .en      (en_q),
    .restart (period_commit),
    .period  (period_q),
    .duty    (duty_q),
    .cnt_q   (cnt_q),
    .wrap    (wrap),
    .pwm_out (pwm_out)
  );

  pwm_autooff #(
    .CNT_W (CNT_W)
  ) i_aoff (
    .clk      (clk),
    .rst      (rst),
    .load     (commit[SLOT_AOFF]),
    .load_val (word_next[SLOT_AOFF]),
    .limit    (aoff_q),
    .wrap     (wrap),
    .expire   (expire)
  );

endmodule

// File: rtl/pwm_bytewise_chk.sv
module pwm_bytewise_chk #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16,
  parameter logic [ADDR_W-1:0] ADR_EN = 8'hA3
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              en_q,
  input logic [CNT_W-1:0]  period_q,
  input logic [CNT_W-1:0]  duty_q,
  input logic [CNT_W-1:0]  aoff_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              period_commit,
  input logic              pwm_out
);

  AST_OFF_IS_LOW: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> !pwm_out);  // R7

  AST_ZERO_PERIOD_LOW: assert property (@(posedge clk) disable iff (rst)
    (period_q == '0) |-> !pwm_out);  // R6

  AST_FULL_DUTY_HIGH: assert property (@(posedge clk) disable iff (rst)
    (en_q && (period_q != '0) && (duty_q >= period_q)) |-> pwm_out);  // R5

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (en_q && (period_q != '0)) |-> (cnt_q < period_q));  // R4

  AST_PERIOD_RESTART: assert property (@(posedge clk) disable iff (rst)
    period_commit |=> (cnt_q == '0));  // R8

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (en_q && (period_q != '0) && !tick && !period_commit) |=> (cnt_q == $past(cnt_q)));  // R12

  AST_AOFF_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (en_q && (aoff_q == {CNT_W{1'b1}}) && !(wr_valid && (wr_addr == ADR_EN))) |=> en_q);  // R11

endmodule

bind pwm_bytewise pwm_bytewise_chk #(
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W),
  .ADR_EN (ADR_EN)
) i_chk (
  .clk           (clk),
  .rst           (rst),
  .tick          (tick),
  .wr_valid      (wr_valid),
  .wr_addr       (wr_addr),
  .en_q          (en_q),
  .period_q      (period_q),
  .duty_q        (duty_q),
  .aoff_q        (aoff_q),
  .cnt_q         (cnt_q),
  .period_commit (period_commit),
  .pwm_out       (pwm_out)
);

// File: tb/test_pwm_bytewise.sv
`timescale 1ns/1ps
module test_pwm_bytewise;

  localparam logic [7:0] A_AO_HI = 8'hA1;
  localparam logic [7:0] A_AO_LO = 8'hA2;
  localparam logic [7:0] A_EN    = 8'hA3;
  localparam logic [7:0] A_PR_LO = 8'hA4;
  localparam logic [7:0] A_PR_HI = 8'hA5;
  localparam logic [7:0] A_DU_LO = 8'hA6;
  localparam logic [7:0] A_DU_HI = 8'hA7;
  localparam int NEVER = 32'h7fffffff;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b1;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwm_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  pwm_bytewise i_pwm_bytewise (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .pwm_out  (pwm_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge, which shows the new state.
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wr_idle(input logic [7:0] a, input logic [7:0] d);
    wr_valid = 1'b0; wr_addr = a; wr_data = d;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; tick = 1'b1; wr_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic setup(input int p, input int d);
    wr(A_PR_HI, 8'((p >> 8) & 255));
    wr(A_PR_LO, 8'(p & 255));
    wr(A_DU_HI, 8'((d >> 8) & 255));
    wr(A_DU_LO, 8'(d & 255));
  endtask

  // Sample n negedges; sample j is at cycle index j+ph since the cycle start.
  task automatic measure(input int p, input int d, input int ph, input int lim,
                         input int n, input string req);
    int bad = 0;
    int act_first = 0;
    int exp_first = 0;
    for (int j = 0; j < n; j++) begin
      int  k = j + ph;
      logic e;
      e = (k < lim) && (p != 0) && ((k % p) < d);
      if (pwm_out !== e) begin
        if (bad == 0) begin act_first = int'(pwm_out); exp_first = int'(e); end
        bad++;
      end
      @(negedge clk);
    end
    check(bad == 0, req, act_first, exp_first);
  endtask

  task automatic t_reset();
    do_reset();
    check(pwm_out === 1'b0, "R1 out low after reset", int'(pwm_out), 0);
    check(wr_ready === 1'b1, "R2 ready high", int'(wr_ready), 1);
    wr(A_EN, 8'h01);
    measure(0, 0, 0, NEVER, 20, "R1/R6 period 0 holds low");
    wr(A_EN, 8'h00);
  endtask

  task automatic t_basic();
    do_reset();
    setup(10, 3);
    wr(A_EN, 8'h01);
    measure(10, 3, 0, NEVER, 40, "R4 P=10 D=3 waveform");
    wr(A_PR_HI, 8'h01);
    measure(10, 3, 41, NEVER, 20, "R3 staged high byte no effect");
    wr(A_PR_LO, 8'h00);
    measure(256, 3, 0, NEVER, 300, "R3 committed {staged,low}=256");
  endtask

  task automatic t_restart_duty();
    do_reset();
    setup(10, 4);
    wr(A_EN, 8'h01);
    measure(10, 4, 0, NEVER, 17, "R4 P=10 D=4 waveform");
    wr(A_PR_LO, 8'd7);
    check(pwm_out === 1'b1, "R8 period commit restarts at tick 0", int'(pwm_out), 1);
    measure(7, 4, 0, NEVER, 30, "R8 new period from tick 0");
    wr(A_DU_LO, 8'd1);
    check(pwm_out === 1'b0, "R9 duty applies without restart", int'(pwm_out), 0);
    measure(7, 1, 31, NEVER, 28, "R9 new duty waveform");
  endtask

  task automatic t_full_zero();
    do_reset();
    setup(5, 5);
    wr(A_EN, 8'h01);
    measure(5, 5, 0, NEVER, 20, "R5 duty==period stays high");
    wr(A_DU_LO, 8'd9);
    measure(5, 9, 0, NEVER, 20, "R5 duty>period stays high");
    wr(A_DU_LO, 8'd0);
    measure(5, 0, 0, NEVER, 20, "R5 duty 0 stays low");
  endtask

  task automatic t_enable();
    do_reset();
    setup(6, 2);
    wr(A_EN, 8'h01);
    measure(6, 2, 0, NEVER, 10, "R4 P=6 D=2 waveform");
    wr(A_EN, 8'hFE);
    measure(6, 0, 0, NEVER, 15, "R7 bit0=0 forces low");
    wr(A_EN, 8'h03);
    measure(6, 2, 0, NEVER, 20, "R7 re-enable starts fresh cycle");
  endtask

  task automatic t_tick();
    int bad = 0;
    do_reset();
    setup(6, 3);
    wr(A_EN, 8'h01);
    measure(6, 3, 0, NEVER, 8, "R4 P=6 D=3 waveform");
    tick = 1'b0;
    for (int j = 0; j < 10; j++) begin
      if (pwm_out !== 1'b1) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R12 no tick holds level", bad, 0);
    tick = 1'b1;
    measure(6, 3, 8, NEVER, 20, "R12 count resumes where held");
  endtask

  task automatic t_ignore();
    do_reset();
    setup(8, 3);
    wr(A_EN, 8'h01);
    measure(8, 3, 0, NEVER, 5, "R4 P=8 D=3 waveform");
    wr(8'hA0, 8'h00);
    wr(8'hA8, 8'h00);
    wr_idle(A_EN, 8'h00);
    wr_idle(A_PR_LO, 8'h01);
    check(wr_ready === 1'b1, "R2 ready stays high", int'(wr_ready), 1);
    measure(8, 3, 9, NEVER, 20, "R13/R2 ignored writes leave waveform");
  endtask

  task automatic t_autooff();
    do_reset();
    setup(5, 2);
    wr(A_AO_HI, 8'h00);
    wr(A_AO_LO, 8'd3);
    wr(A_EN, 8'h01);
    measure(5, 2, 0, 15, 40, "R10 auto-off after 3 periods");
    do_reset();
    setup(5, 2);
    wr(A_AO_HI, 8'h00);
    wr(A_AO_LO, 8'd0);
    wr(A_EN, 8'h01);
    measure(5, 2, 0, 5, 20, "R10 value 0 acts as 1");
    do_reset();
    setup(5, 2);
    wr(A_AO_HI, 8'h00);
    wr(A_AO_LO, 8'd4);
    wr(A_EN, 8'h01);
    measure(5, 2, 0, NEVER, 12, "R10 countdown running");
    wr(A_AO_LO, 8'd4);
    measure(5, 2, 13, 30, 30, "R10 reload mid countdown");
  endtask

  task automatic t_noauto();
    do_reset();
    setup(5, 2);
    wr(A_EN, 8'h01);
    measure(5, 2, 0, NEVER, 100, "R11 reset value 0xFFFF never expires");
    do_reset();
    setup(5, 2);
    wr(A_AO_HI, 8'h00);
    wr(A_AO_LO, 8'd2);
    wr(A_AO_HI, 8'hFF);
    wr(A_AO_LO, 8'hFF);
    wr(A_EN, 8'h01);
    measure(5, 2, 0, NEVER, 100, "R11 written 0xFFFF disables timer");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_restart_duty();
    t_full_zero();
    t_enable();
    t_tick();
    t_ignore();
    t_autooff();
    t_noauto();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule